// File: doc/BRIEF.md
# Triggered Chained-Step Pulse Sequencer

This block produces a one-bit waveform whose edges are spaced by a list of cycle counts fixed at elaboration. The list holds a lead-in delay followed by alternating high and low spans; for example the spans 1, 10, 25, 15 give a one-cycle delay, a ten-cycle pulse, a twenty-five-cycle gap and a fifteen-cycle second pulse. Each entry is served by its own step stage. A stage starts counting when the stage before it has finished, inverts the level handed to it when its count expires, and passes a start token to the next stage. The stages therefore fire strictly in order.

A conditioning front end owns the trigger. The raw input is brought into the clock domain through two flops, and only a rising edge is accepted. An accepted edge opens a run window of a fixed number of cycles, and any activity on the raw input inside that window is ignored. The run window enables every stage. When the window closes, all stages clear and the output returns to the idle level given on `init_level`, so the next accepted edge replays the whole sequence.

Top module: `step_pulser`

## Requirements
- R1: While reset is asserted, and whenever no run window is open, `pulse_out` equals `init_level`.
- R2: A raw trigger rise first sampled at clock edge a opens the run window at edge a+2 (two synchronizer flops, then edge detection). A single-cycle high on `trig_raw` is enough to start it.
- R3: Stage k (counting from 0) completes exactly STEP_LEN[k] cycles after its start. Stage 0 starts at the window opening and stage k>0 starts at the completion of stage k-1, so transition k appears at edge a+2+S_k, where S_k is the sum of the first k+1 lengths.
- R4: Every stage completion inverts the output level, so the output before any completion is `init_level` and it alternates from there.
- R5: After the last stage completes, the output keeps its final level with no further transitions until the run window closes.
- R6: The run window lasts exactly BLOCK_CYCLES cycles. Rising edges and other changes of `trig_raw` inside it neither restart nor extend the sequence.
- R7: At the first edge after the window closes, all stages clear and `pulse_out` returns to `init_level`. That is edge a+3+BLOCK_CYCLES for a rise first sampled at edge a. A later accepted rise replays the identical sequence.
- R8: A raw trigger held high past the end of the window does not start a new sequence. Only a new low-to-high change does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_raw | input | 1 | Unsynchronized trigger input |
| init_level | input | 1 | Idle output level, and the level before the first transition |
| pulse_out | output | 1 | Generated waveform |

## Verification
The assertions assume that `init_level` is static for the length of each run window and that the lengths are nonzero and fit inside the window. Under those assumptions, stage completions form an ordered prefix that only grows while the window is open. The stimulus changes `init_level` only in the idle gaps between windows, with random values. It uses the default lengths, whose sum (51) is below the 60-cycle window. Random toggling of `trig_raw` is confined to the window and to held-high cases, where the block must ignore it.

// File: rtl/step_pulser.sv
module step_pulser #(
  parameter int NUM_STEPS    = 4,
  parameter int LEN_W        = 16,
  parameter logic [NUM_STEPS*LEN_W-1:0] STEP_LEN = {16'd15, 16'd25, 16'd10, 16'd1},
  parameter int BLOCK_CYCLES = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_raw,
  input  logic init_level,
  output logic pulse_out
);

  localparam int BLK_W = (BLOCK_CYCLES > 1) ? $clog2(BLOCK_CYCLES) : 1;

  function automatic int seq_total();
    int t = 0;
    for (int i = 0; i < NUM_STEPS; i++) t += int'(STEP_LEN[i*LEN_W +: LEN_W]);
    return t;
  endfunction

  localparam int TOTAL = seq_total();

  if (TOTAL > BLOCK_CYCLES) begin : g_bad_total
    $error("step lengths exceed the run window");
  end

  logic [2:0]           sync;
  logic                 rise;
  logic                 run;
  logic [BLK_W-1:0]     bcnt;
  logic [NUM_STEPS-1:0] done;
  logic [NUM_STEPS-1:0] go;
  logic [NUM_STEPS:0]   lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], trig_raw};

  assign rise = sync[1] & ~sync[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run  <= 1'b0;
      bcnt <= '0;
    end else if (run) begin
      if (bcnt == '0) run <= 1'b0;
      else            bcnt <= bcnt - 1'b1;
    end else if (rise) begin
      run  <= 1'b1;
      bcnt <= BLK_W'(BLOCK_CYCLES - 1);
    end

  assign go     = {done[NUM_STEPS-2:0], run};
  assign lvl[0] = init_level;

  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
    localparam int D  = int'(STEP_LEN[i*LEN_W +: LEN_W]);
    localparam int CW = (D > 1) ? $clog2(D) : 1;

    if (D == 0) begin : g_bad_len
      $error("step length of zero");
    end

    logic [CW-1:0] cnt;
    logic          fin;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        fin <= 1'b0;
      end else if (!run) begin
        cnt <= '0;
        fin <= 1'b0;
      end else if (go[i] && !fin) begin
        if (cnt == CW'(D - 1)) fin <= 1'b1;
        else                   cnt <= cnt + 1'b1;
      end

    assign done[i]  = fin;
    assign lvl[i+1] = fin ? ~lvl[i] : lvl[i];
  end

  assign pulse_out = lvl[NUM_STEPS];

endmodule

module step_pulser_chk #(
  parameter int N  = 4,
  parameter int BW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [BW-1:0] bcnt,
  input logic [N-1:0]  done
);

  for (genvar i = 1; i < N; i++) begin : g_ord
    a_r3_token_order: assert property (@(posedge clk) disable iff (!rst_n)
      done[i] |-> done[i-1]);
  end

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(done & ~$past(done)) <= 1);

  a_r5_no_drop_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> (($past(done) & ~done) == '0));

  a_r7_clear_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (done == '0));

  a_r7_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (done == '0));

  a_r6_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && bcnt != '0) |=> (run && $past(bcnt) == BW'(bcnt + 1'b1)));

  a_r6_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    (run && bcnt == '0) |=> !run);

endmodule

bind step_pulser step_pulser_chk #(.N(NUM_STEPS), .BW(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .bcnt(bcnt), .done(done)
);

// File: tb/step_pulser_test.sv
module step_pulser_test;
  localparam int NS = 4;
  localparam int B  = 60;
  localparam int LEN [NS] = '{1, 10, 25, 15};

  logic clk = 1'b0, rst_n = 1'b0, trig_raw = 1'b0, init_level = 1'b0;
  logic pulse_out;
  int cyc = 0, checks = 0, fails = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  step_pulser uut (.clk(clk), .rst_n(rst_n), .trig_raw(trig_raw),
                   .init_level(init_level), .pulse_out(pulse_out));

  function automatic bit exp_lvl(int d, bit ini);
    bit l = ini;
    int s = 0;
    if (d >= 4 + B) return ini;
    for (int k = 0; k < NS; k++) begin
      s += LEN[k];
      if (d >= 3 + s) l = ~l;
    end
    return l;
  endfunction

  function automatic string tag_for(int d);
    int tot = 0;
    for (int k = 0; k < NS; k++) tot += LEN[k];
    if (d < 3 + LEN[0])  return "R2";
    if (d < 3 + tot)     return "R3/R4";
    if (d < 4 + B)       return "R5";
    return "R7";
  endfunction

  task automatic check(bit got, bit exp, string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d got=%0b exp=%0b", req, cyc, got, exp);
    end
  endtask

  // mode 0: clean pulse of plen cycles, 1: random glitches inside window (R6), 2: held high (R8)
  task automatic episode(int mode, int plen);
    for (int d = 0; d <= B + 8; d++) begin
      @(negedge clk);
      check(pulse_out, exp_lvl(d, init_level), (mode == 1 && d < 4 + B) ? "R6" : tag_for(d));
      if (d == 0)          trig_raw = 1'b1;
      else if (mode == 2)  trig_raw = 1'b1;
      else if (d >= B)     trig_raw = 1'b0;
      else if (mode == 1)  trig_raw = 1'($urandom % 2);
      else                 trig_raw = (d < plen);
    end
    if (mode == 2) begin
      for (int d = 0; d < 20; d++) begin
        @(negedge clk);
        check(pulse_out, init_level, "R8");
      end
      trig_raw = 1'b0;
    end
  endtask

  task automatic idle_gap(int n);
    @(negedge clk);
    init_level = 1'($urandom % 2);
    trig_raw   = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(pulse_out, init_level, "R1");
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired cyc=%0d", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(pulse_out, 1'b0, "R1");
    init_level = 1'b1;
    @(negedge clk);
    check(pulse_out, 1'b1, "R1");
    rst_n = 1'b1;
    idle_gap(4);
    episode(0, 1);            // R2 single-cycle trigger
    idle_gap(3);
    episode(0, 1);            // R7 replay
    idle_gap(2);
    episode(2, 0);            // R8 held high
    idle_gap(3);
    episode(1, 0);            // R6 glitches in window
    for (int r = 0; r < 16; r++) begin
      idle_gap(1 + int'($urandom % 8));
      episode(int'($urandom % 2), 1 + int'($urandom % B));
    end
    done_flag = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule